// File: doc/BRIEF.md
# I2C Target Read-Data Transmitter

This block is the transmit half of an I2C target. It watches the bus for a START and takes in the address byte that follows. When the seven address bits equal the configured own address and the direction bit asks for a read, it acknowledges the address and switches to sending data. It sends bytes from a local transmit FIFO and reads the master's acknowledge after each byte. Whenever it has to send and the FIFO is empty, it holds SCL low to stretch the clock until the host supplies a byte. A counter limits how long a stretch can last before the host is warned.

The host loads bytes through a valid/ready write port. `wr_ready_o` is high while the FIFO has room, and a byte is taken on any clock where both `wr_valid_i` and `wr_ready_o` are high. A source should hold its byte until it sees ready. A byte offered while ready is low is discarded and raises the overflow flag. The block reports through four sticky flags: data request, stretch timeout, completion and overflow. The host clears a flag by writing a 1 to it. The block also drives an `irq_o` line and a transmit-data-valid status bit.

The bus pins are open-drain. The block only ever pulls a line low, and the surrounding pad logic turns each `*_low_o` output into an output enable.

Top module: `i2c_tgt_tx`

## Requirements
- R1: After a START, the first eight bits sampled on rising SCL edges are taken MSB first as a 7-bit address followed by a direction bit. If the address equals `own_addr_i` and the direction bit is 1, the block pulls SDA low for the ninth (acknowledge) clock and sets the data-request flag (bit 0).
- R2: An address that does not match, or a matching address with direction bit 0, gets no acknowledge (SDA is left released) and leaves every flag unchanged.
- R3: Whenever the block has to send a byte and the FIFO is empty, it holds SCL low (`scl_low_o`=1). It releases SCL in the cycle that follows the arrival of a byte.
- R4: The timeout flag (bit 1) is set once SCL has been stretched for TIMEOUT_CYCLES clocks without a break. A stretch that ends sooner does not set it. The counter restarts from zero at the start of every stretch.
- R5: Data bytes leave in the order they were written, MSB first. SDA is changed only while SCL is low.
- R6: When a byte is taken from the FIFO and two bytes are left behind it, the data-request flag is set.
- R7: If the master acknowledges a byte and the FIFO is then empty, the data-request flag is set, `txdv_o` is 0 and SCL is stretched again.
- R8: If the master does not acknowledge a byte, the completion flag (bit 2) is set when the following STOP is seen, and not before.
- R9: The FIFO holds FIFO_DEPTH bytes, and `wr_ready_o` is 0 while it is full. A write offered while it is full is dropped and sets the overflow flag (bit 3).
- R10: Flags are write-1-to-clear through `flag_clr_i`. Clearing one bit leaves the other bits as they were. `irq_o` is the OR of all flags.
- R11: `txdv_o` is 1 exactly while the FIFO holds at least one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| scl_low_o | output | 1 | Pull SCL low (clock stretch) |
| sda_low_o | output | 1 | Pull SDA low |
| own_addr_i | input | 7 | The block's own 7-bit target address |
| wr_valid_i | input | 1 | Host byte valid |
| wr_data_i | input | 8 | Host byte |
| wr_ready_o | output | 1 | FIFO has room |
| flag_clr_i | input | 4 | Write-1-to-clear mask for the flags |
| flags_o | output | 4 | {overflow, completion, timeout, data request} |
| irq_o | output | 1 | OR of all flags |
| txdv_o | output | 1 | FIFO not empty |

## Verification
Flags, `wr_ready_o` and `txdv_o` change one clock after the host-side event that causes them. Anything caused by a bus edge appears three clocks after the pin changes, because of the two-flop synchronizer and the edge register. The master model in the bench holds every SCL phase for 25 clocks and reads the status at least eight clocks after a bus edge, so every result is settled before it is sampled. The timeout is checked 20 clocks past its limit, and the short stretch ends 200 clocks before the limit, so neither check falls near the cycle where the flag is due.

// File: rtl/i2ctx_pkg.sv
package i2ctx_pkg;
  localparam int NFLAGS   = 4;
  localparam int FLG_DREQ = 0;
  localparam int FLG_TO   = 1;
  localparam int FLG_CMP  = 2;
  localparam int FLG_OVF  = 3;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AHOLD, S_AACK, S_LOAD, S_STRETCH, S_SEND, S_ACK, S_WSTOP
  } tx_state_e;
endpackage

// File: rtl/i2ctx_line_sync.sv
module i2ctx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2ctx_fifo.sv
module i2ctx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign rdata = mem[rp];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_no_pop_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/i2ctx_stretch_timer.sv
module i2ctx_stretch_timer #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT+1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!run)              cnt <= '0;
    else if (cnt != CW'(LIMIT)) cnt <= cnt + CW'(1);
  end

  assign expired = run && (cnt == CW'(LIMIT-1));
endmodule

// File: rtl/i2c_tgt_tx.sv
module i2c_tgt_tx
  import i2ctx_pkg::*;
#(
  parameter int FIFO_DEPTH     = 16,
  parameter int TIMEOUT_CYCLES = 4096,
  parameter int SYNC_STAGES    = 2,
  parameter int LOW_MARK       = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_low_o,
  output logic       sda_low_o,
  input  logic [6:0] own_addr_i,
  input  logic       wr_valid_i,
  input  logic [7:0] wr_data_i,
  output logic       wr_ready_o,
  input  logic [3:0] flag_clr_i,
  output logic [3:0] flags_o,
  output logic       irq_o,
  output logic       txdv_o
);
  localparam int CW = $clog2(FIFO_DEPTH+1);

  logic scl_s, sda_s, scl_rise, scl_fall, line_start, line_stop;
  logic fifo_push, fifo_pop, fifo_full, fifo_empty, to_hit;
  logic [7:0] fifo_rdata;
  logic [CW-1:0] fifo_cnt;

  tx_state_e  state;
  logic [7:0] sh;
  logic [3:0] bitc;
  logic       acked, sda_low, scl_low;
  logic [NFLAGS-1:0] flags_q, flag_set;

  i2ctx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(line_start), .stop_det(line_stop));

  i2ctx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .wdata(wr_data_i),
    .pop(fifo_pop), .rdata(fifo_rdata), .count(fifo_cnt),
    .full(fifo_full), .empty(fifo_empty));

  i2ctx_stretch_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(scl_low), .expired(to_hit));

  assign wr_ready_o = !fifo_full;
  assign fifo_push  = wr_valid_i && !fifo_full;
  assign fifo_pop   = (state == S_LOAD || state == S_STRETCH) && !fifo_empty
                      && !line_start && !line_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; sh <= '0; bitc <= '0; acked <= 1'b0;
      sda_low <= 1'b0; scl_low <= 1'b0;
    end else if (line_start) begin
      state <= S_ADDR; bitc <= '0; sda_low <= 1'b0; scl_low <= 1'b0;
    end else if (line_stop) begin
      state <= S_IDLE; sda_low <= 1'b0; scl_low <= 1'b0;
    end else begin
      unique case (state)
        S_ADDR: if (scl_rise) begin
          sh   <= {sh[6:0], sda_s};
          bitc <= bitc + 4'd1;
          if (bitc == 4'd7)
            state <= ((sh[6:0] == own_addr_i) && sda_s) ? S_AHOLD : S_IDLE;
        end
        S_AHOLD: if (scl_fall) begin
          sda_low <= 1'b1;
          state   <= S_AACK;
        end
        S_AACK: if (scl_fall) begin
          sda_low <= 1'b0;
          state   <= S_LOAD;
        end
        S_LOAD, S_STRETCH: if (!fifo_empty) begin
          sh      <= fifo_rdata;
          sda_low <= !fifo_rdata[7];
          scl_low <= 1'b0;
          bitc    <= '0;
          state   <= S_SEND;
        end else begin
          scl_low <= 1'b1;
          state   <= S_STRETCH;
        end
        S_SEND: begin
          if (scl_rise) bitc <= bitc + 4'd1;
          if (scl_fall) begin
            if (bitc == 4'd8) begin
              sda_low <= 1'b0;
              state   <= S_ACK;
            end else begin
              sh      <= {sh[6:0], 1'b0};
              sda_low <= !sh[6];
            end
          end
        end
        S_ACK: begin
          if (scl_rise) acked <= !sda_s;
          if (scl_fall) state <= acked ? S_LOAD : S_WSTOP;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    flag_set = '0;
    flag_set[FLG_DREQ] = (state == S_AHOLD && scl_fall && !line_start && !line_stop)
                      || (state == S_LOAD && fifo_empty && !line_start && !line_stop)
                      || (fifo_pop && fifo_cnt == CW'(LOW_MARK + 1));
    flag_set[FLG_TO]   = to_hit;
    flag_set[FLG_CMP]  = line_stop && (state == S_WSTOP);
    flag_set[FLG_OVF]  = wr_valid_i && fifo_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~flag_clr_i) | flag_set;
  end

  assign flags_o   = flags_q;
  assign irq_o     = |flags_q;
  assign txdv_o    = !fifo_empty;
  assign scl_low_o = scl_low;
  assign sda_low_o = sda_low;

  assert_sda_moves_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_low) && !$past(line_start) && !$past(line_stop)) |-> !$past(scl_s));
  assert_stretch_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_low && !fifo_empty) |=> !scl_low);
  assert_to_needs_stretch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[FLG_TO]) |-> $past(scl_low));
  assert_cmp_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[FLG_CMP]) |-> $past(line_stop));
  assert_ovf_on_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[FLG_OVF]) |-> $past(wr_valid_i && !wr_ready_o));
endmodule

// File: tb/sim_i2c_tgt_tx.sv
module sim_i2c_tgt_tx;
  localparam int TO = 300;
  localparam int H  = 25;
  localparam int DEPTH = 16;
  localparam logic [6:0] OWN = 7'h3A;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic m_scl_lo = 1'b0, m_sda_lo = 1'b0;
  logic scl_low_o, sda_low_o, wr_valid = 1'b0, wr_ready, irq, txdv;
  logic [7:0] wr_data = '0;
  logic [3:0] clr = '0, flags;
  logic scl_bus, sda_bus;

  assign scl_bus = !(m_scl_lo || scl_low_o);
  assign sda_bus = !(m_sda_lo || sda_low_o);

  i2c_tgt_tx #(.FIFO_DEPTH(DEPTH), .TIMEOUT_CYCLES(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .own_addr_i(OWN),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_ready_o(wr_ready),
    .flag_clr_i(clr), .flags_o(flags), .irq_o(irq), .txdv_o(txdv));

  int n_chk = 0, n_bad = 0;
  logic [7:0] q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    if (wr_ready) q.push_back(d);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic clear(input logic [3:0] m);
    @(negedge clk); clr = m;
    @(negedge clk); clr = '0;
  endtask

  task automatic scl_up();
    m_scl_lo = 1'b0;
    @(negedge clk);
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda_lo = 1'b1; idle(H);
    m_scl_lo = 1'b1; idle(H);
  endtask

  task automatic m_stop();
    m_sda_lo = 1'b1; idle(H);
    scl_up(); idle(H);
    m_sda_lo = 1'b0; idle(H);
  endtask

  task automatic m_wbit(input bit b);
    m_sda_lo = !b; idle(H);
    scl_up(); idle(H);
    m_scl_lo = 1'b1;
  endtask

  task automatic m_rbit(output bit b);
    m_sda_lo = 1'b0; idle(H);
    scl_up(); idle(H/2);
    b = sda_bus; idle(H - H/2);
    m_scl_lo = 1'b1;
  endtask

  task automatic m_wbyte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) m_wbit(v[i]);
  endtask

  task automatic m_rbyte(output logic [7:0] v, input bit ack);
    for (int i = 7; i >= 0; i--) begin
      bit b;
      m_rbit(b);
      v[i] = b;
    end
    m_wbit(!ack);
  endtask

  task automatic read_cmp(input bit ack, input string tag);
    logic [7:0] v, e;
    m_rbyte(v, ack);
    e = (q.size() > 0) ? q.pop_front() : 8'hxx;
    chk(v === e, "R5", tag, v, e);
  endtask

  // Line-rule monitor: DUT may move SDA only while SCL was low
  logic prev_sda_low = 1'b0, prev_scl = 1'b1;
  always @(negedge clk) begin
    if (rst_n && sda_low_o != prev_sda_low)
      chk(!prev_scl, "R5", "SDA changed while SCL high", prev_scl, 0);
    prev_sda_low <= sda_low_o;
    prev_scl <= scl_bus;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    bit a;
    idle(4); rst_n = 1'b1; idle(4);
    chk(flags == 4'h0 && !irq, "R10", "reset flags", flags, 0);
    chk(txdv == 1'b0, "R11", "reset txdv", txdv, 0);
    chk(!scl_low_o && !sda_low_o, "R3", "reset lines", {scl_low_o, sda_low_o}, 0);
    chk(wr_ready == 1'b1, "R9", "reset ready", wr_ready, 1);

    // R2: wrong address, and right address with write direction
    m_start(); m_wbyte({OWN ^ 7'h01, 1'b1}); m_rbit(a); m_stop();
    chk(a == 1'b1, "R2", "no ack other addr", a, 1);
    m_start(); m_wbyte({OWN, 1'b0}); m_rbit(a); m_stop();
    chk(a == 1'b1, "R2", "no ack write dir", a, 1);
    chk(flags == 4'h0, "R2", "flags untouched", flags, 0);

    // R9 fill and overflow
    for (int i = 0; i < DEPTH; i++) push(8'(8'h5A + i * 37));
    chk(wr_ready == 1'b0, "R9", "ready low when full", wr_ready, 0);
    chk(txdv == 1'b1, "R11", "txdv with data", txdv, 1);
    push(8'hEE);
    chk(flags[3] == 1'b1 && irq, "R9", "overflow flag", flags, 8);
    chk(q.size() == DEPTH, "R9", "dropped byte", q.size(), DEPTH);
    clear(4'b1000);
    chk(flags == 4'h0, "R10", "w1c overflow", flags, 0);

    // R1 read address, R5/R6/R7/R8 data
    m_start(); m_wbyte({OWN, 1'b1}); m_rbit(a);
    chk(a == 1'b0, "R1", "address ack", a, 0);
    idle(6);
    chk(flags[0] == 1'b1, "R1", "dreq on entry", flags, 1);
    clear(4'b0001);
    chk(flags == 4'h0, "R10", "w1c dreq", flags, 0);
    for (int k = 1; k <= DEPTH; k++) begin
      read_cmp(1'b1, "fifo byte");
      if (k == 12) chk(flags[0] == 1'b0, "R6", "no early low warn", flags, 0);
      if (k == 14) begin
        chk(flags[0] == 1'b1, "R6", "low warn at two left", flags, 1);
        clear(4'b0001);
      end
    end
    idle(8);
    chk(scl_low_o == 1'b1, "R7", "stretch after ack on empty", scl_low_o, 1);
    chk(txdv == 1'b0, "R7", "txdv cleared", txdv, 0);
    chk(flags[0] == 1'b1, "R7", "dreq on empty", flags, 1);
    fork
      read_cmp(1'b1, "refill byte");
      begin idle(100); push(8'hC3); push(8'h3C); end
    join
    chk(flags[1] == 1'b0, "R4", "short stretch no timeout", flags, 0);
    read_cmp(1'b0, "last byte");
    idle(6);
    chk(flags[2] == 1'b0, "R8", "no cmp before stop", flags, 0);
    m_stop();
    chk(flags[2] == 1'b1, "R8", "cmp after stop", flags, 4);
    clear(4'b1111);

    // R3/R4 timeout
    m_start(); m_wbyte({OWN, 1'b1}); m_rbit(a);
    idle(8);
    chk(scl_low_o == 1'b1, "R3", "stretch on empty entry", scl_low_o, 1);
    idle(TO + 20);
    chk(flags[1] == 1'b1, "R4", "timeout flag", flags, 2);
    chk(scl_low_o == 1'b1, "R3", "still stretched", scl_low_o, 1);
    clear(4'b0001);
    chk(flags == 4'b0010, "R10", "other bits kept", flags, 2);
    fork
      read_cmp(1'b0, "post-timeout byte");
      begin idle(10); push(8'h81); end
    join
    m_stop();
    chk(flags[2] == 1'b1, "R8", "cmp second xfer", flags, 6);
    chk(scl_low_o == 1'b0, "R3", "released", scl_low_o, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule